// File: doc/BRIEF.md
# Serial ADC Digital Port Emulator

This block stands in for the digital side of a successive-approximation converter with a three-wire serial port. The conversion strobe `conv_i` and the serial clock `sck_i` come from a host. A fixed system clock samples both, and all conversion and readout events come from their edges. When the strobe rises, the block captures a parallel sample word and starts an internal conversion timer. When the strobe falls, the block enables its serial output and presents the most significant bit. Each later falling edge of the serial clock moves the next bit onto the output. Once the least significant bit has gone out, further falling edges give zeros.

The block also models the power behaviour of the converter. When a conversion finishes and no readout has begun, the block drops to nap. Serial clock activity brings it back to active. Strobe pulses that arrive with the serial clock idle are counted, and the count selects nap or sleep. Sleep lasts until the serial clock moves again. For a programmable number of system clocks after that, any conversion is flagged as invalid, which models the time the reference needs to recharge.

Top module: `adc_emu_top`

## Requirements
- R1: `sdo_oe_o` is low in every cycle in which `conv_i` is high, including the cycle in which `conv_i` first goes high.
- R2: One cycle after a falling edge of `conv_i` is sampled, `sdo_oe_o` is high and `sdo_o` shows bit DATA_W-1 of the captured word.
- R3: Each sampled falling edge of `sck_i` while the output is enabled moves the next lower bit onto `sdo_o` one cycle later. Without an edge on `sck_i` or `conv_i`, `sdo_o` holds its value.
- R4: The word on `sample_i` is captured in the cycle in which the rising edge of `conv_i` is sampled. Later changes to `sample_i` do not affect the bits shifted out.
- R5: After the least significant bit, every further falling edge of `sck_i` gives `sdo_o` = 0.
- R6: `pwr_state_o` uses the encoding 2'b00 active, 2'b01 nap and 2'b10 sleep. It never shows 2'b11, and it is 2'b00 after reset. CONV_CYCLES cycles after a rising edge of `conv_i`, an active block moves to nap.
- R7: Any sampled edge of `sck_i`, rising or falling, moves the block from nap or sleep to active.
- R8: A block that is not asleep moves to nap when NAP_PULSES rising edges of `conv_i` are counted with no `sck_i` edge in between. SLEEP_PULSES such edges move it to sleep. Sleep holds until an edge of `sck_i`.
- R9: Any edge of `sck_i` clears the count of strobe pulses.
- R10: `conv_invalid_o` is updated at each rising edge of `conv_i`. It is set when that edge occurs in sleep or within WAKE_CYCLES cycles after leaving sleep, and cleared otherwise. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the host signals |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Conversion strobe from the host |
| sck_i | input | 1 | Serial read clock from the host |
| sample_i | input | DATA_W | Parallel word that stands in for the converted value |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; low means high impedance |
| pwr_state_o | output | 2 | Power state: 00 active, 01 nap, 10 sleep |
| conv_invalid_o | output | 1 | Last conversion was started before the reference had recovered |

## Verification
The bench builds the block with DATA_W = 14, CONV_CYCLES = 6 and WAKE_CYCLES = 20, and leaves the pulse thresholds at 2 and 4. With the short conversion time, single-cycle strobe pulses can restart the conversion timer before it expires, so nap by pulse count can be told apart from the automatic nap. With the short wake window, the bench can try a conversion both inside and outside the recovery period within a few dozen cycles.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'b00,
    PWR_NAP    = 2'b01,
    PWR_SLEEP  = 2'b10
  } pwr_state_e;
endpackage

// File: rtl/adc_emu_edge.sv
module adc_emu_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] sig_q;

  for (genvar g = 0; g < N; g++) begin : g_det
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sig_q[g] <= 1'b0;
      else         sig_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~sig_q[g];
    assign fall_o[g] = ~sig_i[g] & sig_q[g];
  end
endmodule

// File: rtl/adc_emu_shifter.sv
module adc_emu_shifter #(
  parameter int DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              enable_i,
  input  logic              shift_i,
  input  logic              conv_lvl_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [DATA_W-1:0] shreg_q;
  logic              en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
    end else if (load_i) begin
      shreg_q <= sample_i;
    end else if (shift_i && en_q) begin
      shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};  // zero fill past LSB
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (load_i)   en_q <= 1'b0;
    else if (enable_i) en_q <= 1'b1;
  end

  assign sdo_o    = shreg_q[DATA_W-1];
  // strobe level gates the enable directly so high-Z is immediate
  assign sdo_oe_o = en_q & ~conv_lvl_i;
endmodule

// File: rtl/adc_emu_power.sv
module adc_emu_power
  import adc_emu_pkg::*;
#(
  parameter int CONV_CYCLES  = 40,
  parameter int WAKE_CYCLES  = 2000,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       conv_rise_i,
  input  logic       sck_edge_i,
  output pwr_state_e pwr_state_o,
  output logic       conv_invalid_o
);
  localparam int CNT_W  = $clog2(SLEEP_PULSES + 1);
  localparam int BUSY_W = $clog2(CONV_CYCLES + 1);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_SLEEP = CNT_W'(SLEEP_PULSES);
  localparam logic [CNT_W-1:0]  CNT_NAP   = CNT_W'(NAP_PULSES);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(CONV_CYCLES);
  localparam logic [WAKE_W-1:0] WAKE_LOAD = WAKE_W'(WAKE_CYCLES);

  pwr_state_e        state_q, state_d;
  logic [CNT_W-1:0]  pulse_q, pulse_d, pulse_base;
  logic [BUSY_W-1:0] busy_q;
  logic [WAKE_W-1:0] wake_q;
  logic              invalid_q;
  logic              conv_done;

  always_comb begin
    pulse_base = sck_edge_i ? '0 : pulse_q;
    pulse_d    = pulse_base;
    if (conv_rise_i && pulse_base != CNT_SLEEP) pulse_d = pulse_base + CNT_W'(1);
  end

  assign conv_done = !conv_rise_i && busy_q == BUSY_W'(1);

  always_comb begin
    state_d = state_q;
    if (conv_done && state_q == PWR_ACTIVE) state_d = PWR_NAP;
    if (sck_edge_i) state_d = PWR_ACTIVE;
    if (conv_rise_i) begin
      if (pulse_d == CNT_SLEEP)                          state_d = PWR_SLEEP;
      else if (pulse_d >= CNT_NAP && state_d != PWR_SLEEP) state_d = PWR_NAP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PWR_ACTIVE;
      pulse_q   <= '0;
      busy_q    <= '0;
      wake_q    <= '0;
      invalid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
      if (conv_rise_i)         busy_q <= BUSY_LOAD;
      else if (busy_q != '0)   busy_q <= busy_q - BUSY_W'(1);
      if (sck_edge_i && state_q == PWR_SLEEP) wake_q <= WAKE_LOAD;
      else if (wake_q != '0)                  wake_q <= wake_q - WAKE_W'(1);
      if (conv_rise_i) invalid_q <= (state_q == PWR_SLEEP) || (wake_q != '0);
    end
  end

  assign pwr_state_o    = state_q;
  assign conv_invalid_o = invalid_q;
endmodule

// File: rtl/adc_emu_top.sv
module adc_emu_top
  import adc_emu_pkg::*;
#(
  parameter int DATA_W       = 14,
  parameter int CONV_CYCLES  = 40,
  parameter int WAKE_CYCLES  = 2000,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_i,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [1:0]        pwr_state_o,
  output logic              conv_invalid_o
);
  localparam int IDX_CONV = 0;
  localparam int IDX_SCK  = 1;

  logic [1:0] rise, fall;
  logic       sck_edge;
  pwr_state_e pwr_state;

  adc_emu_edge #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({sck_i, conv_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sck_edge = rise[IDX_SCK] | fall[IDX_SCK];

  adc_emu_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rise[IDX_CONV]),
    .sample_i   (sample_i),
    .enable_i   (fall[IDX_CONV]),
    .shift_i    (fall[IDX_SCK]),
    .conv_lvl_i (conv_i),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o)
  );

  adc_emu_power #(
    .CONV_CYCLES  (CONV_CYCLES),
    .WAKE_CYCLES  (WAKE_CYCLES),
    .NAP_PULSES   (NAP_PULSES),
    .SLEEP_PULSES (SLEEP_PULSES)
  ) u_pwr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .conv_rise_i    (rise[IDX_CONV]),
    .sck_edge_i     (sck_edge),
    .pwr_state_o    (pwr_state),
    .conv_invalid_o (conv_invalid_o)
  );

  assign pwr_state_o = pwr_state;
endmodule

// File: rtl/adc_emu_checker.sv
module adc_emu_checker
  import adc_emu_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       conv_i,
  input logic       sck_i,
  input logic       sdo_o,
  input logic       sdo_oe_o,
  input logic [1:0] pwr_state_o,
  input logic       conv_invalid_o
);
  assert_oe_after_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $fell(conv_i)) |=> (sdo_oe_o || conv_i));

  assert_sdo_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable(sck_i) && $stable(conv_i)) |=> $stable(sdo_o));

  assert_state_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_state_o != 2'b11);

  assert_sleep_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && pwr_state_o == PWR_SLEEP && $stable(sck_i)) |=> pwr_state_o == PWR_SLEEP);

  assert_sleep_invalid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && pwr_state_o == PWR_SLEEP && $rose(conv_i)) |=> conv_invalid_o);
endmodule

bind adc_emu_top adc_emu_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .conv_i         (conv_i),
  .sck_i          (sck_i),
  .sdo_o          (sdo_o),
  .sdo_oe_o       (sdo_oe_o),
  .pwr_state_o    (pwr_state_o),
  .conv_invalid_o (conv_invalid_o)
);

// File: tb/adc_emu_top_tb.sv
`timescale 1ns/1ps
module adc_emu_top_tb;
  localparam int DATA_W = 14;
  localparam int CONV_C = 6;
  localparam int WAKE_C = 20;
  localparam logic [1:0] ST_ACT = 2'b00, ST_NAP = 2'b01, ST_SLP = 2'b10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              conv = 1'b0;
  logic              sck = 1'b0;
  logic [DATA_W-1:0] sample = '0;
  logic              sdo, sdo_oe, invalid;
  logic [1:0]        pwr;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_emu_top #(
    .DATA_W(DATA_W), .CONV_CYCLES(CONV_C), .WAKE_CYCLES(WAKE_C),
    .NAP_PULSES(2), .SLEEP_PULSES(4)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv), .sck_i(sck), .sample_i(sample),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .pwr_state_o(pwr), .conv_invalid_o(invalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_toggle();
    @(negedge clk) sck = 1'b1;
    @(negedge clk) sck = 1'b0;
    @(negedge clk);
  endtask

  task automatic conv_pulse();
    @(negedge clk) conv = 1'b1;
    @(negedge clk) conv = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R6 reset state", pwr, ST_ACT);
    check("R1 reset oe", sdo_oe, 0);
    check("R10 reset invalid", invalid, 0);
  endtask

  task automatic t_readout(input logic [DATA_W-1:0] word);
    @(negedge clk) begin sample = word; conv = 1'b1; end
    @(negedge clk) sample = ~word;  // changed after capture, R4
    check("R1 oe while conv high", sdo_oe, 0);
    cycles(CONV_C + 1);
    check("R6 auto nap", pwr, ST_NAP);
    check("R1 oe still low", sdo_oe, 0);
    @(negedge clk) conv = 1'b0;
    @(negedge clk);
    check("R2 oe after fall", sdo_oe, 1);
    check("R2 msb R4", sdo, word[DATA_W-1]);
    for (int i = DATA_W - 2; i >= 0; i--) begin
      sck_toggle();
      check("R3 shifted bit R4", sdo, word[i]);
    end
    for (int i = 0; i < 3; i++) begin
      sck_toggle();
      check("R5 zero pad", sdo, 0);
    end
    check("R7 active after readout", pwr, ST_ACT);
  endtask

  task automatic t_oe_gate();
    @(negedge clk) begin sample = 14'h3FFF; conv = 1'b1; end
    cycles(2);
    @(negedge clk) conv = 1'b0;
    @(negedge clk);
    sck_toggle();
    check("R3 second bit", sdo, 1);
    @(negedge clk) conv = 1'b1;
    #1 check("R1 immediate high-Z", sdo_oe, 0);
    cycles(2);
    @(negedge clk) conv = 1'b0;
    cycles(CONV_C + 2);
  endtask

  task automatic t_pulse_modes();
    sck_toggle();
    check("R7 active after sck", pwr, ST_ACT);
    conv_pulse();
    check("R8 one pulse stays active", pwr, ST_ACT);
    conv_pulse();
    check("R8 two pulses nap", pwr, ST_NAP);
    conv_pulse();
    sck_toggle();
    check("R7 nap to active", pwr, ST_ACT);
    for (int i = 0; i < 3; i++) conv_pulse();
    check("R9 count cleared, no sleep", pwr, ST_NAP);
    sck_toggle();
    for (int i = 0; i < 4; i++) conv_pulse();
    check("R8 four pulses sleep", pwr, ST_SLP);
  endtask

  task automatic t_sleep_wake();
    conv_pulse();
    check("R10 invalid in sleep", invalid, 1);
    cycles(CONV_C + 3);
    check("R8 sleep holds", pwr, ST_SLP);
    sck_toggle();
    check("R7 sleep exit", pwr, ST_ACT);
    conv_pulse();
    check("R10 invalid in wake window", invalid, 1);
    cycles(WAKE_C + 5);
    conv_pulse();
    check("R10 valid after wake", invalid, 0);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_readout(14'h2A5B);
    t_readout(14'h15A4);
    t_oe_gate();
    t_pulse_modes();
    t_sleep_wake();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule